// File: doc/BRIEF.md
# Fuse Array Automatic Access Sequencer

This block stands between a small register interface and a one-time-programmable fuse macro. Software writes a control word naming a fuse address and a direction. The sequencer then runs a complete read or program access on its own. It drives the macro's chip select (active low), program enable (active low), load, address and strobe pins. Each pin has its own start offset and active length, and there is one set of windows for reading and a separate set for programming. A read returns a 32-bit word that is kept in a data register. Every completed access raises a finish flag.

The array is organised as 32 rows of 32 bits, and the row is the low five bits of the fuse address. One program access blows exactly one bit: bit k of row r lives at address r + 32·k. To program a word, software issues one program access for each set bit. Rows 0 to 23 form the secure bank and the remaining rows form the non-secure bank. A request whose privilege does not match the bank of its row raises an error flag, and the macro is never touched. The three status flags are gated by an enable mask onto one interrupt line.

Top module: `fuse_auto_seq`

## Requirements
- R1: After reset the register reads are as follows. Mode (offset 0x00), interrupt enable (0x04), status (0x08) and data (0x10) all read 0. The macro pins are idle: chip select high, program enable high, load low, strobe low, address 0. The program window registers (0x20 + 4·p) read start 1 / length 241 for pins p = 0..3 and start 2 / length 240 for p = 4. The read window registers (0x34 + 4·p) read start 1 / length 4 for p = 0..3 and start 2 / length 3 for p = 4. The pin order is chip select, program enable, load, address, strobe. Every window register holds the start in bits 31:16 and the length in bits 15:0.
- R2: An access starts when the control register (0x0C) is written with bit 0 = 1 while the mode is auto and no access runs. Bit 1 selects the direction (1 = read, 0 = program) and bits 25:16 give the 10-bit fuse address.
- R3: Let c be the number of cycles since the start write, with c = 0 in the first cycle after it. A pin is active while start ≤ c < start + length of its window in the selected set. Chip select and program enable are low when active. Load and strobe are high when active. The address pins show the fuse address while their window is active and 0 otherwise.
- R4: A read uses the read set and never asserts program enable. A program access uses the program set and never asserts load.
- R5: Let T be the largest start + length over the five windows of the selected set. Status bit 0 (finish) reads 1 from cycle c = T + 1 and reads 0 at c = T.
- R6: A read stores the macro's output word into the data register on the clock edge that ends the last strobe cycle.
- R7: A request from a non-secure requester to a row below 24 sets status bit 1. A request from a secure requester to a row of 24 or above sets status bit 2. The flag is visible at c = 0, no macro pin moves and finish is not set.
- R8: Writing the status register clears exactly the flags written as 1.
- R9: The interrupt output equals the OR of the status bits ANDed with the enable register bits 2:0.
- R10: With mode bit 0 = 1 (manual mode), writes to the control register start nothing and raise no flag.
- R11: A control write while an access runs is ignored: the running access, its address and its data are unchanged, and the control register still reads the old address.
- R12: A program access produces one strobe pulse at its address, which sets that single bit. Programming a word bit by bit at r + 32·k makes a later read of row r return the programmed bits together with the bits that were already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset, used for both writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_secure | input | 1 | Privilege of the requester issuing the write (1 = secure) |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt: OR of the enabled status flags |
| fuse_csb_n | output | 1 | Macro chip select, active low |
| fuse_pgenb_n | output | 1 | Macro program enable, active low |
| fuse_load | output | 1 | Macro load, active high |
| fuse_strobe | output | 1 | Macro strobe, active high |
| fuse_addr | output | 10 | Macro fuse address |
| fuse_dout | input | 32 | Macro read data |

## Verification
The bench sweeps every row with both requester privileges and compares every pin in every cycle of each legal access against windows computed from its own timing table. It also expects each illegal request to raise exactly the correct one of the two error flags while all pins stay idle. An off-by-one in the window compare, or in the end-of-access count, shifts a pin edge or the finish cycle and is caught in that cycle. A capture edge that is one cycle late samples a macro output that has already dropped and returns zero data. The bench programs words both with the default 242-cycle windows and with short custom windows, then reads them back. A design that mixed up the read and program sets, or drove load during programming, would corrupt the array model. Separate checks confirm that manual mode and writes during a running access leave the address, the data and the flags unchanged, and that clearing one status flag keeps the others.

// File: rtl/fuse_seq_pkg.sv
`timescale 1ns/1ps
package fuse_seq_pkg;
   localparam int NUM_PINS = 5;
   localparam int HALF_W   = 16;

   // pin order inside every window set
   localparam int PIN_CSB  = 0;
   localparam int PIN_PGM  = 1;
   localparam int PIN_LOAD = 2;
   localparam int PIN_ADR  = 3;
   localparam int PIN_STB  = 4;

   typedef struct packed {
      logic [HALF_W-1:0] first;
      logic [HALF_W-1:0] span;
   } pin_win_t;

   localparam logic [7:0] RA_MODE  = 8'h00;
   localparam logic [7:0] RA_IEN   = 8'h04;
   localparam logic [7:0] RA_ISTAT = 8'h08;
   localparam logic [7:0] RA_CTRL  = 8'h0C;
   localparam logic [7:0] RA_DOUT  = 8'h10;
   localparam logic [7:0] RA_TPROG = 8'h20;
   localparam logic [7:0] RA_TREAD = 8'h34;

   localparam int CTRL_GO      = 0;
   localparam int CTRL_DIR     = 1;
   localparam int CTRL_ADR_LSB = 16;

   localparam int FLAG_DONE  = 0;
   localparam int FLAG_NS2S  = 1;
   localparam int FLAG_S2NS  = 2;
   localparam int NUM_FLAGS  = 3;

   function automatic pin_win_t default_win(input logic is_read, input int pin);
      pin_win_t w;
      w.first = (pin == PIN_STB) ? 16'd2 : 16'd1;
      if (is_read) w.span = (pin == PIN_STB) ? 16'd3   : 16'd4;
      else         w.span = (pin == PIN_STB) ? 16'd240 : 16'd241;
      return w;
   endfunction
endpackage

// File: rtl/fuse_pin_window.sv
`timescale 1ns/1ps
module fuse_pin_window
   import fuse_seq_pkg::*;
#(
   parameter int SUM_W = HALF_W + 1
) (
   input  logic             run,
   input  logic [SUM_W-1:0] tick,
   input  pin_win_t         win,
   output logic             on
);
   logic [SUM_W-1:0] lo_b;
   logic [SUM_W-1:0] hi_b;

   assign lo_b = SUM_W'(win.first);
   assign hi_b = SUM_W'(win.first) + SUM_W'(win.span);
   assign on   = run && (tick >= lo_b) && (tick < hi_b);
endmodule

// File: rtl/fuse_timing_bank.sv
`timescale 1ns/1ps
module fuse_timing_bank
   import fuse_seq_pkg::*;
#(
   parameter int REG_AW = 8,
   parameter int SUM_W  = HALF_W + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [REG_AW-1:0]         wr_addr,
   input  logic [31:0]               wr_data,
   input  logic                      use_read,
   input  logic [REG_AW-1:0]         rd_addr,
   output pin_win_t [NUM_PINS-1:0]   act_win,
   output logic [SUM_W-1:0]          run_len,
   output logic                      rd_hit,
   output logic [31:0]               rd_data
);
   localparam int NUM_WIN = 2 * NUM_PINS;

   pin_win_t [NUM_WIN-1:0] all_win;

   function automatic int win_ofs(input int idx);
      if (idx < NUM_PINS) return int'(RA_TPROG) + 4 * idx;
      return int'(RA_TREAD) + 4 * (idx - NUM_PINS);
   endfunction

   for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
      localparam logic IS_RD = (gi >= NUM_PINS);
      localparam int   PIN   = IS_RD ? gi - NUM_PINS : gi;
      pin_win_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= default_win(IS_RD, PIN);
         else if (wr_en && wr_addr == REG_AW'(win_ofs(gi)))
            q <= wr_data;
      end
      assign all_win[gi] = q;
   end

   always_comb begin
      run_len = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
         act_win[p] = use_read ? all_win[NUM_PINS + p] : all_win[p];
         if (SUM_W'(act_win[p].first) + SUM_W'(act_win[p].span) > run_len)
            run_len = SUM_W'(act_win[p].first) + SUM_W'(act_win[p].span);
      end
   end

   always_comb begin
      rd_hit  = 1'b0;
      rd_data = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (rd_addr == REG_AW'(win_ofs(i))) begin
            rd_hit  = 1'b1;
            rd_data = all_win[i];
         end
      end
   end
endmodule

// File: rtl/fuse_irq_status.sv
`timescale 1ns/1ps
module fuse_irq_status #(
   parameter int NFLAG = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] raise,
   input  logic             clr_wr,
   input  logic [NFLAG-1:0] clr_bits,
   input  logic             en_wr,
   input  logic [NFLAG-1:0] en_bits,
   output logic [NFLAG-1:0] flags,
   output logic [NFLAG-1:0] mask,
   output logic             irq
);
   logic [NFLAG-1:0] wipe;

   assign wipe = clr_wr ? clr_bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         mask  <= '0;
      end else begin
         flags <= (flags & ~wipe) | raise;
         if (en_wr) mask <= en_bits;
      end
   end

   assign irq = |(flags & mask);

   // R8
   w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && raise == '0) |=> ((flags & $past(clr_bits)) == '0));

   // R8
   w1c_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && raise == '0) |=> ((flags & ~$past(clr_bits)) == ($past(flags) & ~$past(clr_bits))));
endmodule

// File: rtl/fuse_auto_seq.sv
`timescale 1ns/1ps
module fuse_auto_seq
   import fuse_seq_pkg::*;
#(
   parameter int ADDR_W   = 10,
   parameter int DATA_W   = 32,
   parameter int ROW_W    = 5,
   parameter int SEC_ROWS = 24,
   parameter int REG_AW   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              reg_secure,
   output logic [31:0]       reg_rdata,
   output logic              irq,
   output logic              fuse_csb_n,
   output logic              fuse_pgenb_n,
   output logic              fuse_load,
   output logic              fuse_strobe,
   output logic [ADDR_W-1:0] fuse_addr,
   input  logic [DATA_W-1:0] fuse_dout
);
   localparam int SUM_W = HALF_W + 1;
   localparam logic [ROW_W:0] SEC_LIM = (ROW_W + 1)'(SEC_ROWS);

   if (ROW_W > ADDR_W || SEC_ROWS > (1 << ROW_W) || DATA_W > 32 ||
       CTRL_ADR_LSB + ADDR_W > 32 || REG_AW < 7) begin : g_cfg_bad
      $error("fuse_auto_seq: inconsistent parameters");
   end

   logic                  mode_user;
   logic                  ctl_go, ctl_rd;
   logic [ADDR_W-1:0]     ctl_addr;
   logic                  busy;
   logic [SUM_W-1:0]      cnt;
   logic [DATA_W-1:0]     dout_q;
   pin_win_t [NUM_PINS-1:0] act_win;
   logic [SUM_W-1:0]      run_len;
   logic                  tb_hit;
   logic [31:0]           tb_rdata;
   logic [NUM_PINS-1:0]   pin_on;
   logic [NUM_FLAGS-1:0]  stat_q, ien_q, raise;

   // ---------------- request decode ----------------
   logic             wr_ctrl, start_req, row_sec, err_ns, err_s, go;
   logic [ROW_W-1:0] req_row;

   assign wr_ctrl   = reg_wr && (reg_addr == REG_AW'(RA_CTRL));
   assign start_req = wr_ctrl && reg_wdata[CTRL_GO] && !mode_user && !busy;
   assign req_row   = reg_wdata[CTRL_ADR_LSB +: ROW_W];
   assign row_sec   = {1'b0, req_row} < SEC_LIM;
   assign err_ns    = start_req && row_sec && !reg_secure;
   assign err_s     = start_req && !row_sec && reg_secure;
   assign go        = start_req && !err_ns && !err_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_user <= 1'b0;
         ctl_go    <= 1'b0;
         ctl_rd    <= 1'b0;
         ctl_addr  <= '0;
      end else begin
         if (reg_wr && reg_addr == REG_AW'(RA_MODE)) mode_user <= reg_wdata[0];
         if (wr_ctrl && !busy) begin
            ctl_go   <= reg_wdata[CTRL_GO];
            ctl_rd   <= reg_wdata[CTRL_DIR];
            ctl_addr <= reg_wdata[CTRL_ADR_LSB +: ADDR_W];
         end
      end
   end

   // ---------------- access counter ----------------
   logic done;
   assign done = busy && (cnt == run_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (go) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (busy) begin
         if (done) busy <= 1'b0;
         else      cnt  <= cnt + 1'b1;
      end
   end

   // ---------------- window timing ----------------
   fuse_timing_bank #(.REG_AW(REG_AW), .SUM_W(SUM_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .wr_addr (reg_addr),
      .wr_data (reg_wdata),
      .use_read(ctl_rd),
      .rd_addr (reg_addr),
      .act_win (act_win),
      .run_len (run_len),
      .rd_hit  (tb_hit),
      .rd_data (tb_rdata)
   );

   for (genvar gp = 0; gp < NUM_PINS; gp++) begin : g_pin
      fuse_pin_window #(.SUM_W(SUM_W)) u_win (
         .run (busy),
         .tick(cnt),
         .win (act_win[gp]),
         .on  (pin_on[gp])
      );
   end

   assign fuse_csb_n   = !pin_on[PIN_CSB];
   assign fuse_pgenb_n = !(pin_on[PIN_PGM] && !ctl_rd);
   assign fuse_load    = pin_on[PIN_LOAD] && ctl_rd;
   assign fuse_strobe  = pin_on[PIN_STB];
   assign fuse_addr    = pin_on[PIN_ADR] ? ctl_addr : '0;

   // ---------------- read capture ----------------
   logic [SUM_W-1:0] stb_end;
   logic             cap;
   assign stb_end = SUM_W'(act_win[PIN_STB].first) + SUM_W'(act_win[PIN_STB].span);
   assign cap     = busy && ctl_rd && (act_win[PIN_STB].span != '0) &&
                    (SUM_W'(cnt + 1'b1) == stb_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   dout_q <= '0;
      else if (cap) dout_q <= fuse_dout;
   end

   // ---------------- status and interrupt ----------------
   always_comb begin
      raise            = '0;
      raise[FLAG_DONE] = done;
      raise[FLAG_NS2S] = err_ns;
      raise[FLAG_S2NS] = err_s;
   end

   fuse_irq_status #(.NFLAG(NUM_FLAGS)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .raise   (raise),
      .clr_wr  (reg_wr && reg_addr == REG_AW'(RA_ISTAT)),
      .clr_bits(reg_wdata[NUM_FLAGS-1:0]),
      .en_wr   (reg_wr && reg_addr == REG_AW'(RA_IEN)),
      .en_bits (reg_wdata[NUM_FLAGS-1:0]),
      .flags   (stat_q),
      .mask    (ien_q),
      .irq     (irq)
   );

   // ---------------- register read ----------------
   logic [31:0] ctl_view;
   always_comb begin
      ctl_view = '0;
      ctl_view[CTRL_GO]  = ctl_go;
      ctl_view[CTRL_DIR] = ctl_rd;
      ctl_view[CTRL_ADR_LSB +: ADDR_W] = ctl_addr;
   end

   always_comb begin
      reg_rdata = '0;
      if      (reg_addr == REG_AW'(RA_MODE))  reg_rdata = {31'b0, mode_user};
      else if (reg_addr == REG_AW'(RA_IEN))   reg_rdata = 32'(ien_q);
      else if (reg_addr == REG_AW'(RA_ISTAT)) reg_rdata = 32'(stat_q);
      else if (reg_addr == REG_AW'(RA_CTRL))  reg_rdata = ctl_view;
      else if (reg_addr == REG_AW'(RA_DOUT))  reg_rdata = 32'(dout_q);
      else if (tb_hit)                        reg_rdata = tb_rdata;
   end

   // ---------------- assertions ----------------
   // R3
   idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (fuse_csb_n && fuse_pgenb_n && !fuse_load && !fuse_strobe && fuse_addr == '0));

   // R4
   dir_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (ctl_rd ? fuse_pgenb_n : !fuse_load));

   // R5
   finish_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[FLAG_DONE]) |-> ($past(busy) && !busy));

   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt <= run_len));

   // R7
   err_no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_ns || err_s) |=> !busy);

   // R10
   user_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_user && !busy) |=> !busy);

   // R11
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_ctrl) |=> ($stable(ctl_addr) && $stable(ctl_rd)));
endmodule

// File: tb/test_fuse_auto_seq.sv
`timescale 1ns/1ps
module test_fuse_auto_seq;
   import fuse_seq_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        reg_secure = 1'b0;
   logic [31:0] reg_rdata;
   logic        irq;
   logic        fuse_csb_n, fuse_pgenb_n, fuse_load, fuse_strobe;
   logic [9:0]  fuse_addr;
   logic [31:0] fuse_dout;

   always #4 clk = ~clk;

   fuse_auto_seq i_fuse_auto_seq (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_secure(reg_secure), .reg_rdata(reg_rdata),
      .irq(irq), .fuse_csb_n(fuse_csb_n), .fuse_pgenb_n(fuse_pgenb_n),
      .fuse_load(fuse_load), .fuse_strobe(fuse_strobe), .fuse_addr(fuse_addr),
      .fuse_dout(fuse_dout)
   );

   // ---------------- fuse macro model ----------------
   bit          fuse_img [1024];
   bit          exp_img  [1024];
   logic [31:0] row_word;

   always_comb begin
      for (int k = 0; k < 32; k++) row_word[k] = fuse_img[k * 32 + int'(fuse_addr[4:0])];
   end
   assign fuse_dout = (fuse_strobe && fuse_load && !fuse_csb_n) ? row_word : 32'h0;

   always @(posedge fuse_strobe)
      if (!fuse_pgenb_n && !fuse_csb_n) fuse_img[fuse_addr] = 1'b1;

   // ---------------- bookkeeping ----------------
   int n_cmp = 0;
   int n_bad = 0;
   int tb_s [2][5];
   int tb_l [2][5];

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_word(input int r);
      logic [31:0] w;
      for (int k = 0; k < 32; k++) w[k] = exp_img[k * 32 + r];
      return w;
   endfunction

   function automatic int total_of(input int rs);
      int t = 0;
      for (int p = 0; p < 5; p++) if (tb_s[rs][p] + tb_l[rs][p] > t) t = tb_s[rs][p] + tb_l[rs][p];
      return t;
   endfunction

   function automatic logic [31:0] exp_pins(input int rs, input int j, input int tot, input int adr);
      logic [4:0] a;
      for (int p = 0; p < 5; p++)
         a[p] = (j <= tot) && (j >= tb_s[rs][p]) && (j < tb_s[rs][p] + tb_l[rs][p]);
      return 32'({!a[0], !(a[1] && rs == 0), a[2] && rs == 1, a[4], a[3] ? 10'(adr) : 10'd0});
   endfunction

   function automatic logic [31:0] pins_now();
      return 32'({fuse_csb_n, fuse_pgenb_n, fuse_load, fuse_strobe, fuse_addr});
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic sec);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_secure = sec;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic set_win(input int rs, input int p, input int s, input int l);
      tb_s[rs][p] = s;
      tb_l[rs][p] = l;
      wr((rs == 1 ? RA_TREAD : RA_TPROG) + 8'(4 * p), {16'(s), 16'(l)}, 1'b0);
   endtask

   // one legal access with per-cycle pin comparison
   task automatic access(input int rs, input int adr, input logic sec, input string rq);
      int tot;
      logic [31:0] d;
      tot = total_of(rs);
      wr(RA_CTRL, (32'(adr) << 16) | (32'(rs) << 1) | 32'h1, sec);
      for (int j = 0; j <= tot + 1; j++) begin
         if (j > 0) @(negedge clk);
         chk({rq, " R3,R4 pins"}, pins_now(), exp_pins(rs, j, tot, adr));
         if (j == tot) begin
            rd(RA_ISTAT, d);
            chk("R5 finish early", d, 32'h0);
         end
      end
      rd(RA_ISTAT, d);
      chk("R5 finish", d, 32'h1);
      if (rs == 1) begin
         rd(RA_DOUT, d);
         chk({rq, " R6 data"}, d, exp_word(adr % 32));
      end else begin
         exp_img[adr] = 1'b1;
      end
      wr(RA_ISTAT, 32'h7, 1'b0);
      wr(RA_CTRL, (32'(adr) << 16) | (32'(rs) << 1), sec);
   endtask

   task automatic err_access(input int adr, input logic sec, input logic [31:0] flag);
      logic [31:0] d;
      wr(RA_CTRL, (32'(adr) << 16) | 32'h3, sec);
      rd(RA_ISTAT, d);
      chk("R7 error flag", d, flag);
      for (int j = 0; j < 4; j++) begin
         if (j > 0) @(negedge clk);
         chk("R7 pins idle", pins_now(), exp_pins(1, j, -1, adr));
      end
      rd(RA_ISTAT, d);
      chk("R7 no finish", d, flag);
      wr(RA_ISTAT, 32'h7, 1'b0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      for (int r = 0; r < 32; r++)
         for (int k = 0; k < 32; k++) begin
            fuse_img[k * 32 + r] = (((r * 7 + k * 3) % 5) == 0);
            exp_img[k * 32 + r]  = (((r * 7 + k * 3) % 5) == 0);
         end
      for (int p = 0; p < 5; p++) begin
         tb_s[0][p] = (p == 4) ? 2 : 1;  tb_l[0][p] = (p == 4) ? 240 : 241;
         tb_s[1][p] = (p == 4) ? 2 : 1;  tb_l[1][p] = (p == 4) ? 3 : 4;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(RA_MODE, d);  chk("R1 mode", d, 0);
      rd(RA_IEN, d);   chk("R1 ien", d, 0);
      rd(RA_ISTAT, d); chk("R1 status", d, 0);
      rd(RA_DOUT, d);  chk("R1 dout", d, 0);
      chk("R1 pins", pins_now(), exp_pins(1, 0, -1, 0));
      chk("R1 irq", 32'(irq), 0);
      for (int rs = 0; rs < 2; rs++)
         for (int p = 0; p < 5; p++) begin
            rd((rs == 1 ? RA_TREAD : RA_TPROG) + 8'(4 * p), d);
            chk("R1 window", d, {16'(tb_s[rs][p]), 16'(tb_l[rs][p])});
         end

      // R2 R7 sweep: every row, both privileges, default read windows
      for (int sec = 0; sec < 2; sec++)
         for (int r = 0; r < 32; r++) begin
            if ((sec == 1) == (r < 24)) access(1, r, 1'(sec), "R2 sweep");
            else err_access(r, 1'(sec), (sec == 1) ? 32'h4 : 32'h2);
         end

      // R12 program row 25 with default windows (bits 0, 2, 31)
      access(0, 25, 1'b0, "R12 prog");
      access(0, 25 + 64, 1'b0, "R12 prog");
      access(0, 25 + 992, 1'b0, "R12 prog");
      access(1, 25, 1'b0, "R12 reread");

      // R3 custom program windows, program row 5 (secure)
      set_win(0, 0, 0, 7); set_win(0, 1, 1, 5); set_win(0, 2, 1, 5);
      set_win(0, 3, 1, 6); set_win(0, 4, 2, 3);
      rd(RA_TPROG + 8'd16, d);
      chk("R3 window readback", d, {16'd2, 16'd3});
      access(0, 5 + 32, 1'b1, "R12 prog");
      access(0, 5 + 128, 1'b1, "R12 prog");
      access(0, 5 + 288, 1'b1, "R12 prog");
      access(0, 5 + 960, 1'b1, "R12 prog");
      access(1, 5, 1'b1, "R12 reread");

      // R6 custom read windows
      set_win(1, 0, 0, 9); set_win(1, 1, 0, 9); set_win(1, 2, 1, 7);
      set_win(1, 3, 2, 5); set_win(1, 4, 3, 2);
      access(1, 5, 1'b1, "R6 custom");
      access(1, 25, 1'b0, "R6 custom");
      access(1, 13, 1'b1, "R6 custom");

      // R11 control write during an access is ignored
      set_win(1, 0, 0, 20);
      wr(RA_CTRL, (32'd26 << 16) | 32'h3, 1'b0);
      @(negedge clk);
      wr(RA_CTRL, (32'd27 << 16) | 32'h3, 1'b0);
      rd(RA_CTRL, d);
      chk("R11 ctrl addr", (d >> 16) & 32'h3FF, 26);
      repeat (8) @(negedge clk);
      chk("R11 addr pins", 32'(fuse_addr), 0);
      repeat (20) @(negedge clk);
      rd(RA_ISTAT, d); chk("R11 one finish", d, 32'h1);
      rd(RA_DOUT, d);  chk("R11 data", d, exp_word(26));
      chk("R11 idle", pins_now(), exp_pins(1, 0, -1, 0));
      wr(RA_ISTAT, 32'h7, 1'b0);

      // R8 R9 status clearing and interrupt gating
      wr(RA_CTRL, (32'd3 << 16) | 32'h3, 1'b0);
      wr(RA_CTRL, (32'd24 << 16) | 32'h3, 1'b0);
      repeat (25) @(negedge clk);
      rd(RA_ISTAT, d); chk("R8 both flags", d, 32'h3);
      chk("R9 irq masked", 32'(irq), 0);
      wr(RA_IEN, 32'h1, 1'b0);
      chk("R9 irq on", 32'(irq), 1);
      wr(RA_IEN, 32'h4, 1'b0);
      chk("R9 irq other bit", 32'(irq), 0);
      wr(RA_ISTAT, 32'h2, 1'b0);
      rd(RA_ISTAT, d); chk("R8 partial clear", d, 32'h1);
      wr(RA_IEN, 32'h1, 1'b0);
      chk("R9 irq finish", 32'(irq), 1);
      wr(RA_ISTAT, 32'h7, 1'b0);
      rd(RA_ISTAT, d); chk("R8 full clear", d, 32'h0);
      chk("R9 irq cleared", 32'(irq), 0);

      // R10 manual mode ignores starts
      wr(RA_MODE, 32'h1, 1'b0);
      rd(RA_MODE, d); chk("R10 mode", d, 1);
      wr(RA_CTRL, (32'd24 << 16) | 32'h3, 1'b0);
      for (int j = 0; j < 8; j++) begin
         if (j > 0) @(negedge clk);
         chk("R10 pins idle", pins_now(), exp_pins(1, 0, -1, 0));
      end
      wr(RA_CTRL, (32'd3 << 16) | 32'h3, 1'b0);
      @(negedge clk);
      rd(RA_ISTAT, d); chk("R10 no flags", d, 0);
      wr(RA_MODE, 32'h0, 1'b0);
      access(1, 30, 1'b0, "R10 back to auto");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule